// File: doc/BRIEF.md
# Nine-bit multidrop serial data path

This block is the data path of a 16550-style serial port that can switch into 9-bit framing for multidrop field buses. In that mode the ninth data bit replaces parity. Software loads the ninth transmit bit into a scratch register. Its next write to the transmit data register then pushes a 9-bit entry into the transmit FIFO, and the transmitter sends that entry as one frame.

On the receive side, each character goes into a FIFO together with four status bits: overrun, ninth bit (parity error in normal mode), framing error and break. The ninth bit does three jobs:
- It marks address characters. Address characters can raise a top-priority interrupt.
- It takes part in a comparison against four programmable 9-bit patterns. A match raises a low-priority interrupt.
- It never counts as an error.

The bit tick inputs come from an external rate generator. Both the transmitter and the receiver work one bit per tick, in 1x isochronous fashion. DEPTH must be a power of two.

Top module: `nbit_uart`

## Requirements
- R1: After reset the line status (address 2) reads 0x60, irq is low with irq_level 0, and txd is high.
- R2: With 9-bit mode on (address 5 bit 0), each transmit entry goes out as one start bit (0), nine data bits LSB first and one stop bit (1), one bit per tx_tick. The ninth bit is scratch register (address 4) bit 0 at the time of the write to address 0. The length and parity fields of address 3 have no effect.
- R3: Transmit entries leave in the order they were written.
- R4: In 9-bit mode a received frame carries nine data bits. Address 0 returns the low eight bits and pops the entry. Line status bit 2 shows the ninth bit of the head entry, and bit 0 shows that data is ready. Address 3 has no effect.
- R5: Line status bit 7 is 1 while any stored entry has an overrun, framing error or break (or, in normal mode, a parity error). A ninth bit of 1 never sets it.
- R6: A stop bit sampled as 0 sets framing error (status bit 3). If all data bits and the stop bit are 0, break (status bit 4) is also set.
- R7: With address 1 bit 2 set, storing a character that has an error raises irq_level 1. Reading address 2 clears it.
- R8: With address 5 bit 2 set, storing a character whose ninth bit is 1 raises irq_level 1. If no error is pending, line status bits 7 and 1 read 0.
- R9: With address 5 bit 1 set, a stored character equal to an enabled 9-bit pattern raises irq_level 5. Pattern k has its low byte at address 6+k, and address 10 holds ninth bit k at bit k and enable k at bit 4+k. Address 11 returns a hit flag per pattern (bit k) and the read clears it.
- R10: A character that completes while the receive FIFO is full is dropped, and the overrun flag (status bit 1) is set on the last stored entry.
- R11: In normal mode, address 3 sets the data length (bits 1:0, length 5 plus the field) and parity (bit 3 enables it, bit 4 selects even). A parity mismatch shows in line status bit 2.
- R12: irq_level gives level 1 priority over level 2 (address 1 bit 0 set with data ready), and level 2 priority over level 5. irq is high exactly when irq_level is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reads of addresses 0, 2 and 11 have side effects) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of the address |
| tx_tick | input | 1 | One pulse per transmit bit time |
| txd | output | 1 | Serial transmit line |
| rx_tick | input | 1 | One pulse per receive bit sample |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Interrupt request |
| irq_level | output | 3 | Active interrupt level: 0, 1, 2 or 5 |

## Verification
The receiver stores a character on the clock edge that samples its stop bit. Line status, data ready and irq_level therefore change at that edge, and the bench reads them from the falling edge that follows the last driven bit. Each transmit bit appears on txd one edge after its tick. The scoreboard samples txd at the falling edge after each tick and compares every finished frame with the entry queued when it was written. Register reads sample rdata within the strobe cycle. Pops and interrupt clears take effect at that cycle's edge, so the next read or irq_level sample shows the cleared state.

// File: rtl/nbit_uart.sv
module nbit_uart #(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tx_tick,
  output logic       txd,
  input  logic       rx_tick,
  input  logic       rxd,
  output logic       irq,
  output logic [2:0] irq_level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_STOP} rxs_t;

  logic [7:0] ier, lcr, scr, nmr, pctl;
  logic [7:0] pat [4];
  logic       nine, pen;
  logic [3:0] nd;

  assign nine = nmr[0];
  assign pen  = !nine && lcr[3];
  assign nd   = nine ? 4'd9 : 4'd5 + {2'b0, lcr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier <= '0; lcr <= '0; scr <= '0; nmr <= '0; pctl <= '0;
      for (int k = 0; k < 4; k++) pat[k] <= '0;
    end else if (wr_en) begin
      case (addr)
        4'd1: ier <= wdata;
        4'd3: lcr <= wdata;
        4'd4: scr <= wdata;
        4'd5: nmr <= wdata;
        4'd6, 4'd7, 4'd8, 4'd9: pat[addr[1:0] - 2'd2] <= wdata;
        4'd10: pctl <= wdata;
        default: ;
      endcase
    end
  end

  // transmit FIFO and shifter
  logic [8:0]  tmem [DEPTH];
  logic [CW-1:0] twp, trp;
  logic        tempty, tfull, tpush, tpop;
  logic        tbusy;
  logic [11:0] tsh, tframe;
  logic [3:0]  tcnt, tbits;
  logic [8:0]  thd;

  assign tempty = twp == trp;
  assign tfull  = (twp[AW] != trp[AW]) && (twp[AW-1:0] == trp[AW-1:0]);
  assign tpush  = wr_en && addr == 4'd0 && !tfull;
  assign tpop   = tx_tick && !tempty && (!tbusy || tcnt == 4'd1);
  assign thd    = tmem[trp[AW-1:0]];

  always_comb begin
    logic x;
    x = 1'b0;
    tframe = '1;
    tframe[0] = 1'b0;
    for (int i = 0; i < 9; i++)
      if (i < int'(nd)) begin
        tframe[i+1] = thd[i];
        x = x ^ thd[i];
      end
    if (pen) tframe[int'(nd)+1] = lcr[4] ? x : ~x;
    tbits = nd + 4'd2 + {3'b0, pen};
  end

  always_ff @(posedge clk)
    if (tpush) tmem[twp[AW-1:0]] <= {nine ? scr[0] : 1'b0, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tbusy <= 1'b0; tsh <= '1; tcnt <= '0;
    end else begin
      if (tpush) twp <= twp + 1'b1;
      if (tpop)  trp <= trp + 1'b1;
      if (tx_tick) begin
        if (tbusy && tcnt > 4'd1) begin
          tsh  <= {1'b1, tsh[11:1]};
          tcnt <= tcnt - 4'd1;
        end else if (!tempty) begin
          tsh <= tframe; tcnt <= tbits; tbusy <= 1'b1;
        end else begin
          tsh <= '1; tbusy <= 1'b0;
        end
      end
    end
  end

  assign txd = tbusy ? tsh[0] : 1'b1;

  // receiver
  rxs_t       rxs;
  logic [9:0] rbuf;
  logic [3:0] ridx, rneed;
  logic       rx_done, rx_push, ovr;
  logic [8:0] rch;
  logic       rpe, rbrk;
  logic [4:0] nst;

  assign rneed   = nd + {3'b0, pen};
  assign rx_done = rx_tick && rxs == RX_STOP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxs <= RX_IDLE; ridx <= '0; rbuf <= '0;
    end else if (rx_tick) begin
      case (rxs)
        RX_IDLE: if (!rxd) begin rxs <= RX_DATA; ridx <= '0; end
        RX_DATA: begin
          rbuf[ridx] <= rxd;
          if (ridx == rneed - 4'd1) rxs <= RX_STOP;
          else ridx <= ridx + 4'd1;
        end
        default: rxs <= RX_IDLE;
      endcase
    end
  end

  always_comb begin
    logic x;
    logic rpar;
    x = 1'b0;
    rch = '0;
    for (int i = 0; i < 9; i++)
      if (i < int'(nd)) begin
        rch[i] = rbuf[i];
        x = x ^ rbuf[i];
      end
    rpar = rbuf[nd];
    rpe  = pen && (rpar != (lcr[4] ? x : ~x));
    rbrk = !rxd && rch == '0 && !(pen && rpar);
    // {error, break, framing, ninth-or-parity, overrun}
    nst = {rpe || !rxd, rbrk, !rxd, nine ? rch[8] : rpe, 1'b0};
  end

  // receive FIFO
  logic [7:0]    rmem [DEPTH];
  logic [4:0]    smem [DEPTH];
  logic [CW-1:0] rwp, rrp, ecnt;
  logic          rempty, rfull, rpop, lerr;
  logic [4:0]    rhs;
  logic [AW-1:0] rlast;

  assign rempty  = rwp == rrp;
  assign rfull   = (rwp[AW] != rrp[AW]) && (rwp[AW-1:0] == rrp[AW-1:0]);
  assign rx_push = rx_done && !rfull;
  assign ovr     = rx_done && rfull;
  assign rpop    = rd_en && addr == 4'd0 && !rempty;
  assign rhs     = smem[rrp[AW-1:0]];
  assign rlast   = rwp[AW-1:0] - 1'b1;
  assign lerr    = smem[rlast][4];

  always_ff @(posedge clk) begin
    if (rx_push) begin
      rmem[rwp[AW-1:0]] <= rch[7:0];
      smem[rwp[AW-1:0]] <= nst;
    end
    if (ovr) smem[rlast] <= smem[rlast] | 5'b10001;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; ecnt <= '0;
    end else begin
      if (rx_push) rwp <= rwp + 1'b1;
      if (rpop)    rrp <= rrp + 1'b1;
      ecnt <= ecnt + CW'((rx_push && nst[4]) || (ovr && !lerr))
                   - CW'(rpop && rhs[4]);
    end
  end

  // interrupts
  logic       ls_pend, adr_pend, lsr_rd, mrd;
  logic [3:0] hit, mhits;

  assign lsr_rd = rd_en && addr == 4'd2;
  assign mrd    = rd_en && addr == 4'd11;

  always_comb
    for (int k = 0; k < 4; k++)
      hit[k] = pctl[4+k] && {pctl[k], pat[k]} == rch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_pend <= 1'b0; adr_pend <= 1'b0; mhits <= '0;
    end else begin
      ls_pend  <= (ls_pend && !lsr_rd) || (rx_push && nst[4]) || ovr;
      adr_pend <= (adr_pend && !lsr_rd) || (rx_push && nine && nmr[2] && rch[8]);
      mhits    <= (mrd ? 4'b0 : mhits) | ((rx_push && nine && nmr[1]) ? hit : 4'b0);
    end
  end

  logic l1, l2, l5;
  assign l1 = (ls_pend && ier[2]) || adr_pend;
  assign l2 = ier[0] && !rempty;
  assign l5 = |mhits;
  assign irq       = l1 || l2 || l5;
  assign irq_level = l1 ? 3'd1 : l2 ? 3'd2 : l5 ? 3'd5 : 3'd0;

  // register read
  logic [7:0] lsr;
  assign lsr = {ecnt != '0, tempty && !tbusy, tempty,
                rhs[3:0] & {4{!rempty}}, !rempty};

  always_comb begin
    case (addr)
      4'd0: rdata = rmem[rrp[AW-1:0]];
      4'd1: rdata = ier;
      4'd2: rdata = lsr;
      4'd3: rdata = lcr;
      4'd4: rdata = scr;
      4'd5: rdata = nmr;
      4'd6, 4'd7, 4'd8, 4'd9: rdata = pat[addr[1:0] - 2'd2];
      4'd10: rdata = pctl;
      4'd11: rdata = {4'b0, mhits};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/nbit_uart_chk.sv
module nbit_uart_chk #(
  parameter int DEPTH = 128
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    rd_en,
  input logic [3:0]              addr,
  input logic                    irq,
  input logic [2:0]              irq_level,
  input logic                    txd,
  input logic                    tbusy,
  input logic                    rx_push,
  input logic                    ovr,
  input logic                    ls_pend,
  input logic                    adr_pend,
  input logic [$clog2(DEPTH):0]  rwp,
  input logic [$clog2(DEPTH):0]  rrp
);
  localparam int CW = $clog2(DEPTH) + 1;

  a_r12_level_code: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level inside {3'd0, 3'd1, 3'd2, 3'd5}) && (irq == (irq_level != 3'd0)));

  a_r2_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbusy) |-> !txd);

  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 4'd2 && !rx_push && !ovr) |=> (!ls_pend && !adr_pend));

  a_r10_drop_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> rwp == $past(rwp));

  a_r10_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(rwp - rrp) <= CW'(DEPTH));
endmodule

bind nbit_uart nbit_uart_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .irq(irq),
  .irq_level(irq_level), .txd(txd), .tbusy(tbusy), .rx_push(rx_push),
  .ovr(ovr), .ls_pend(ls_pend), .adr_pend(adr_pend), .rwp(rwp), .rrp(rrp)
);

// File: tb/nbit_uart_tb_top.sv
module nbit_uart_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       txd, irq;
  logic [2:0] irq_level;

  nbit_uart #(.DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tx_tick(tick), .txd(txd),
    .rx_tick(tick), .rxd(rxd), .irq(irq), .irq_level(irq_level)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // tick generator and transmit monitor (scoreboard side)
  logic [8:0] txq[$];
  int tc = 0, mst = 0, mn = 0;
  logic [8:0] msh = '0;
  always @(negedge clk) begin
    if (tick) begin
      case (mst)
        0: if (txd == 1'b0) begin mst = 1; mn = 0; msh = '0; end
        1: begin msh[mn] = txd; mn++; if (mn == 9) mst = 2; end
        default: begin
          logic [8:0] e;
          chk("R2 stop bit", int'(txd), 1);
          if (txq.size() == 0) chk("R3 unexpected frame", 1, 0);
          else begin
            e = txq.pop_front();
            chk("R2/R3 tx frame", int'(msh), int'(e));
          end
          mst = 0;
        end
      endcase
    end
    tc = (tc + 1) % 4;
    tick = (tc == 0);
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; addr = 4'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = 4'(a);
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, int'(d), exp);
  endtask

  task automatic tx9(logic b9, logic [7:0] b);
    wr(4, int'(b9));
    wr(0, int'(b));
    txq.push_back({b9, b});
  endtask

  task automatic rx_bit(logic b);
    rxd = b;
    do @(posedge clk); while (!tick);
    @(negedge clk);
  endtask

  task automatic rx_frame(logic [9:0] bits, int n, logic stopb);
    rx_bit(1'b0);
    for (int i = 0; i < n; i++) rx_bit(bits[i]);
    rx_bit(stopb);
    rxd = 1'b1;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 line status", 2, 8'h60);
    chk("R1 irq_level", int'(irq_level), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 txd idle", int'(txd), 1);

    // R2/R3 transmit in 9-bit mode with a conflicting line control value
    wr(5, 8'h01);
    wr(3, 8'h18);
    tx9(1'b1, 8'hA5);
    tx9(1'b0, 8'h3C);
    do rd(2, d); while (!(d[6] && txq.size() == 0));
    chk("R3 queue drained", txq.size(), 0);

    // R4/R5 receive ninth bit, no summary error
    rx_frame(10'h155, 9, 1'b1);
    rd_chk("R4/R5 status ninth bit", 2, 8'h65);
    chk("R4 no irq", int'(irq_level), 0);
    rd_chk("R4 low byte", 0, 8'h55);
    rd_chk("R4 empty after pop", 2, 8'h60);

    // R8 address interrupt
    wr(5, 8'h05);
    rx_frame(10'h1C3, 9, 1'b1);
    chk("R8 address irq level", int'(irq_level), 1);
    rd_chk("R8 status bits 7 and 1 clear", 2, 8'h65);
    chk("R8 cleared by status read", int'(irq_level), 0);
    rd_chk("R8 data", 0, 8'hC3);
    rx_frame(10'h0C3, 9, 1'b1);
    chk("R8 data char no irq", int'(irq_level), 0);
    rd_chk("R8 data char status", 2, 8'h61);
    rd_chk("R8 data char byte", 0, 8'hC3);

    // R6/R7 framing error and break
    wr(1, 8'h04);
    rx_frame(10'h012, 9, 1'b0);
    chk("R7 error irq level", int'(irq_level), 1);
    rd_chk("R6/R5 framing status", 2, 8'hE9);
    chk("R7 cleared by status read", int'(irq_level), 0);
    rd_chk("R6 framing data", 0, 8'h12);
    rd_chk("R5 summary clears", 2, 8'h60);
    rx_frame(10'h000, 9, 1'b0);
    rd_chk("R6 break status", 2, 8'hF9);
    rd_chk("R6 break data", 0, 8'h00);
    wr(1, 8'h00);

    // R9 pattern match
    wr(5, 8'h03);
    wr(6, 8'hAA);
    wr(8, 8'h7E);
    wr(10, 8'h51);
    rx_frame(10'h0AA, 9, 1'b1);
    chk("R9 ninth bit differs, no match", int'(irq_level), 0);
    rd(0, d);
    rx_frame(10'h1AA, 9, 1'b1);
    chk("R9 match level", int'(irq_level), 5);
    rd_chk("R9 hit pattern 0", 11, 8'h01);
    chk("R9 cleared by read", int'(irq_level), 0);
    rd(0, d);
    rx_frame(10'h07E, 9, 1'b1);
    rd_chk("R9 hit pattern 2", 11, 8'h04);
    rd(0, d);

    // R12 priority
    wr(5, 8'h07);
    rx_frame(10'h1AA, 9, 1'b1);
    chk("R12 level 1 over 5", int'(irq_level), 1);
    rd(2, d);
    chk("R12 level 5 remains", int'(irq_level), 5);
    rd(11, d);
    chk("R12 none after clear", int'(irq_level), 0);
    wr(1, 8'h01);
    chk("R12 data ready level 2", int'(irq_level), 2);
    rd(0, d);
    chk("R12 level 2 gone after pop", int'(irq_level), 0);
    chk("R12 irq low", int'(irq), 0);
    wr(1, 8'h00);

    // R10 overrun with four-entry FIFO
    wr(5, 8'h01);
    rx_frame(10'h101, 9, 1'b1);
    rx_frame(10'h002, 9, 1'b1);
    rx_frame(10'h003, 9, 1'b1);
    rx_frame(10'h004, 9, 1'b1);
    rx_frame(10'h005, 9, 1'b1);
    rd_chk("R10/R5 summary after overrun", 2, 8'hE5);
    rd_chk("R10 entry 1", 0, 8'h01);
    rd_chk("R10 entry 2", 0, 8'h02);
    rd_chk("R10 entry 3", 0, 8'h03);
    rd_chk("R10 overrun on last entry", 2, 8'hE3);
    rd_chk("R10 entry 4", 0, 8'h04);
    rd_chk("R10 dropped character", 2, 8'h60);

    // R11 normal mode parity: 7 bits, even parity
    wr(5, 8'h00);
    wr(3, 8'h1A);
    rx_frame({2'b0, 1'b1, 7'h35}, 8, 1'b1);
    rd_chk("R11 parity error status", 2, 8'hE5);
    rd_chk("R11 data", 0, 8'h35);
    rx_frame({2'b0, 1'b0, 7'h35}, 8, 1'b1);
    rd_chk("R11 good parity status", 2, 8'h61);
    rd_chk("R11 good data", 0, 8'h35);

    report();
    $finish;
  end
endmodule